// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request inputs and presents a single interrupt output to a processor. Software programs the controller through a small register port. The port has an address bit, a chip select, read and write strobes, and an 8-bit data bus. When the processor takes the interrupt, it pulses an acknowledge input. The controller answers with an 8-bit vector: a programmed base plus the number of the winning input.

Before use, software runs a four-word set-up sequence. After that it can mask inputs, read back the pending-request or in-service register, and retire a level with a specific end-of-interrupt command. In automatic end-of-interrupt mode, the acknowledge itself retires the level. Priority is fixed, with input 0 highest. A request with higher priority than the level in service can interrupt it, so nesting is possible. An acknowledge that finds nothing eligible returns the vector of input 7 and changes no state. The second set-up word is the word that places one controller in a chain of two: a bitmask of inputs in a primary, an identity value in a secondary. The controller accepts this word and counts it in the sequence, but drives no chaining address lines.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the interrupt output is low, the mask register is 0xFF, the vector output is 0, and command-port reads return the request register, which reads 0.
- R2: A command-port write (reg_sel=0) with bit 4 set, for example 0x11, starts set-up. It clears the mask, request and in-service registers and selects the request register for readback. The next three data-port writes (reg_sel=1) are taken as the vector base, the chaining word and the mode word. They do not change the mask.
- R3: Outside set-up, a data-port write loads the mask register, and a data-port read returns it. A 1 in bit n blocks input n.
- R4: A rising edge on request input n sets request bit n, whatever the mask. A request held high does not set the bit again once it has been cleared.
- R5: The interrupt output is high exactly when some unmasked request bit has a lower level number than every in-service bit. Input 0 has the highest priority.
- R6: An acknowledge while the interrupt output is high picks the lowest-numbered unmasked pending level n. On the next cycle the vector output reads base+n (mod 256), request bit n is clear, and in-service bit n is set.
- R7: When bit 1 of the mode word is 1 (automatic end of interrupt), an acknowledge returns the vector and clears the request bit but leaves the in-service register unchanged.
- R8: A command-port write of 0x60+n (bits 7:3 = 01100, bits 2:0 = n) clears in-service bit n and no other bit.
- R9: A command-port write of 0x0B makes later command-port reads return the in-service register. A write of 0x0A makes them return the request register. The selection holds until it is changed.
- R10: An acknowledge while the interrupt output is low returns base+7 and leaves the request and in-service registers unchanged, even when input 7 is masked.
- R11: While level n is in service, a new request at level n or lower priority keeps the interrupt output low. A request at a higher-priority level raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select for the register port |
| reg_sel | input | 1 | Address bit: 0 selects the command port, 1 the data port |
| rd_stb | input | 1 | Read strobe; with cs, drives rdata |
| wr_stb | input | 1 | Write strobe; with cs, writes wdata on the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; 0 when no read is selected |
| req_in | input | 8 | Edge-triggered request inputs, bit 0 highest priority |
| irq_out | output | 1 | Interrupt output to the processor |
| ack_stb | input | 1 | Single-cycle interrupt acknowledge |
| vec_out | output | 8 | Vector from the last acknowledge, updated the cycle after it |

## Verification
The assertions assume that a write, an acknowledge and a change of the request inputs never fall in the same cycle. They also assume that a set-up start is not combined with a request edge. Under those assumptions, each register has one source of change per cycle. The random stimulus issues one operation per cycle: a request toggle, a mask write, an acknowledge, an end-of-interrupt, a readback select or a read. Re-initialization is rare and always uses the full four-word sequence. This keeps the bench's reference model in step with the controller at every cycle boundary.

// File: rtl/pic_pkg.sv
// Package: shared constants and types for the priority interrupt controller.
// Assumes an 8-bit processor bus; the command encodings below rely on that width.
package pic_pkg;
    localparam int DATA_W = 8;
    localparam int INIT_BIT = 4;                        // command bit that starts set-up
    localparam int AEOI_BIT = 1;                        // mode-word bit for automatic EOI
    localparam logic [DATA_W-1:0] CMD_RD_REQ = 8'h0A;   // readback: request register
    localparam logic [DATA_W-1:0] CMD_RD_SVC = 8'h0B;   // readback: in-service register
    localparam logic [4:0] CMD_SEOI_TAG = 5'b01100;     // bits 7:3 of a specific EOI

    typedef enum logic [1:0] {
        CFG_READY = 2'd0,
        CFG_BASE  = 2'd1,
        CFG_CHAIN = 2'd2,
        CFG_MODE  = 2'd3
    } cfg_state_t;
endpackage

// File: rtl/pic_lowest_set.sv
// Module: finds the lowest-numbered set bit of a vector (highest priority).
// Assumes bit 0 has the highest priority; idx is 0 when no bit is set.
module pic_lowest_set #(
    parameter int N_IN = 8,
    localparam int LVL_W = $clog2(N_IN)
) (
    input  logic [N_IN-1:0]  bits,
    output logic             any,
    output logic [LVL_W-1:0] idx
);
    // Purpose: scan from the lowest priority down so the lowest set index wins.
    always_comb begin
        any = |bits;
        idx = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (bits[i]) idx = LVL_W'(i);
        end
    end
endmodule

// File: rtl/pic_cfg_regs.sv
// Module: set-up sequencer, mask register, vector base, mode and readback select.
// Assumes command and data writes are one-cycle strobes; a set-up start
// overrides anything else in the same cycle.
module pic_cfg_regs
    import pic_pkg::*;
#(
    parameter int N_IN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [N_IN-1:0]   mask_q,
    output logic [DATA_W-1:0] base_q,
    output logic              aeoi_q,
    output logic              sel_svc_q,
    output logic              init_pulse
);
    cfg_state_t state_q;

    // Purpose: flag a command write that starts the set-up sequence.
    always_comb init_pulse = cmd_wr && wdata[INIT_BIT];

    // Purpose: walk the set-up words and hold the programmed configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= CFG_READY;
            mask_q    <= '1;
            base_q    <= '0;
            aeoi_q    <= 1'b0;
            sel_svc_q <= 1'b0;
        end else if (init_pulse) begin
            state_q   <= CFG_BASE;
            mask_q    <= '0;
            sel_svc_q <= 1'b0;
        end else begin
            if (cmd_wr) begin
                if (wdata == CMD_RD_REQ) sel_svc_q <= 1'b0;
                else if (wdata == CMD_RD_SVC) sel_svc_q <= 1'b1;
            end
            if (dat_wr) begin
                case (state_q)
                    CFG_READY: mask_q <= wdata[N_IN-1:0];
                    CFG_BASE: begin
                        base_q  <= wdata;
                        state_q <= CFG_CHAIN;
                    end
                    CFG_CHAIN: state_q <= CFG_MODE;
                    CFG_MODE: begin
                        aeoi_q  <= wdata[AEOI_BIT];
                        state_q <= CFG_READY;
                    end
                    default: state_q <= CFG_READY;
                endcase
            end
        end
    end

    // R3: a data write outside set-up lands in the mask register.
    assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !cmd_wr && state_q == CFG_READY) |=> (mask_q == $past(wdata[N_IN-1:0])));

    // R2: set-up start clears the mask and selects request readback.
    assert_init_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> (mask_q == '0 && !sel_svc_q && state_q == CFG_BASE));

    // R2: set-up words never reach the mask register.
    assert_init_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !cmd_wr && state_q != CFG_READY) |=> $stable(mask_q));
endmodule

// File: rtl/pic_service_regs.sv
// Module: request edge capture, in-service tracking, priority decision and vector.
// Assumes acknowledge is a one-cycle pulse and that base/mask are stable
// configuration registers.
module pic_service_regs
    import pic_pkg::*;
#(
    parameter int N_IN = 8,
    localparam int LVL_W = $clog2(N_IN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   req_in,
    input  logic [N_IN-1:0]   mask,
    input  logic [DATA_W-1:0] base,
    input  logic              aeoi,
    input  logic              init_pulse,
    input  logic              eoi_wr,
    input  logic [LVL_W-1:0]  eoi_lvl,
    input  logic              ack_stb,
    output logic [N_IN-1:0]   irr_q,
    output logic [N_IN-1:0]   isr_q,
    output logic              irq_out,
    output logic [DATA_W-1:0] vec_q
);
    localparam logic [DATA_W-1:0] SPUR_LVL = DATA_W'(N_IN - 1);

    logic [N_IN-1:0]  req_prev_q;
    logic [N_IN-1:0]  rise;
    logic [N_IN-1:0]  pend;
    logic [N_IN-1:0]  win_hot;
    logic [N_IN-1:0]  isr_next;
    logic             pend_any;
    logic             svc_any;
    logic [LVL_W-1:0] pend_idx;
    logic [LVL_W-1:0] svc_idx;
    logic             grant;

    pic_lowest_set #(.N_IN(N_IN)) u_pend_enc (
        .bits(pend),
        .any (pend_any),
        .idx (pend_idx)
    );

    pic_lowest_set #(.N_IN(N_IN)) u_svc_enc (
        .bits(isr_q),
        .any (svc_any),
        .idx (svc_idx)
    );

    // Purpose: form edges, eligible requests and the interrupt decision.
    always_comb begin
        rise    = req_in & ~req_prev_q;
        pend    = irr_q & ~mask;
        irq_out = pend_any && (!svc_any || pend_idx < svc_idx);
        grant   = ack_stb && irq_out;
        win_hot = N_IN'(1) << pend_idx;
    end

    // Purpose: next in-service value; EOI clears first, a grant then sets.
    always_comb begin
        isr_next = isr_q;
        if (eoi_wr) isr_next[eoi_lvl] = 1'b0;
        if (grant && !aeoi) isr_next = isr_next | win_hot;
    end

    // Purpose: remember the previous request levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_prev_q <= '0;
        else req_prev_q <= req_in;
    end

    // Purpose: request register; set by rising edges, cleared on grant or set-up.
    always_ff @(posedge clk) begin
        if (!rst_n || init_pulse) irr_q <= '0;
        else irr_q <= (irr_q & ~(grant ? win_hot : '0)) | rise;
    end

    // Purpose: in-service register.
    always_ff @(posedge clk) begin
        if (!rst_n || init_pulse) isr_q <= '0;
        else isr_q <= isr_next;
    end

    // Purpose: latch the vector on every acknowledge, spurious or real.
    always_ff @(posedge clk) begin
        if (!rst_n) vec_q <= '0;
        else if (ack_stb) vec_q <= grant ? base + DATA_W'(pend_idx) : base + SPUR_LVL;
    end

    // R4: a rising edge on an input leaves its request bit set.
    for (genvar k = 0; k < N_IN; k++) begin : g_edge_chk
        assert_edge_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (req_in[k] && !req_prev_q[k] && !init_pulse) |=> irr_q[k]);
    end

    // R5: all inputs masked means no interrupt.
    assert_all_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq_out);

    // R6: a normal-mode grant adds exactly one in-service level.
    assert_grant_nests_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && irq_out && !aeoi && !eoi_wr && !init_pulse)
        |=> ($countones(isr_q) == $countones($past(isr_q)) + 1));

    // R7: automatic EOI leaves the in-service register alone.
    assert_auto_eoi_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && aeoi && !eoi_wr && !init_pulse) |=> $stable(isr_q));

    // R8: a specific EOI leaves its level clear.
    assert_seoi_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !ack_stb && !init_pulse) |=> !isr_q[$past(eoi_lvl)]);

    // R10: a spurious acknowledge returns the lowest-priority vector.
    assert_spurious_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && !irq_out) |=> (vec_q == $past(base) + SPUR_LVL));

    // R10: a spurious acknowledge touches neither register.
    assert_spurious_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && !irq_out && !eoi_wr && !init_pulse && rise == '0)
        |=> ($stable(isr_q) && $stable(irr_q)));
endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: top of the eight-input fixed-priority interrupt controller.
// Decodes the register port, routes commands and returns readback data.
// Assumes a single processor bus master and one-cycle strobes.
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int N_IN = 8,
    localparam int LVL_W = $clog2(N_IN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              reg_sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_IN-1:0]   req_in,
    output logic              irq_out,
    input  logic              ack_stb,
    output logic [DATA_W-1:0] vec_out
);
    logic              cmd_wr;
    logic              dat_wr;
    logic              eoi_wr;
    logic              init_pulse;
    logic              aeoi;
    logic              sel_svc;
    logic [N_IN-1:0]   mask;
    logic [N_IN-1:0]   irr;
    logic [N_IN-1:0]   isr;
    logic [DATA_W-1:0] base;

    // Purpose: split bus writes into command, data and specific-EOI strobes.
    always_comb begin
        cmd_wr = cs && wr_stb && !reg_sel;
        dat_wr = cs && wr_stb && reg_sel;
        eoi_wr = cmd_wr && (wdata[DATA_W-1:3] == CMD_SEOI_TAG);
    end

    pic_cfg_regs #(.N_IN(N_IN)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .dat_wr    (dat_wr),
        .wdata     (wdata),
        .mask_q    (mask),
        .base_q    (base),
        .aeoi_q    (aeoi),
        .sel_svc_q (sel_svc),
        .init_pulse(init_pulse)
    );

    pic_service_regs #(.N_IN(N_IN)) u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_in    (req_in),
        .mask      (mask),
        .base      (base),
        .aeoi      (aeoi),
        .init_pulse(init_pulse),
        .eoi_wr    (eoi_wr),
        .eoi_lvl   (wdata[LVL_W-1:0]),
        .ack_stb   (ack_stb),
        .irr_q     (irr),
        .isr_q     (isr),
        .irq_out   (irq_out),
        .vec_q     (vec_out)
    );

    // Purpose: drive readback data for the selected port, zero otherwise.
    always_comb begin
        rdata = '0;
        if (cs && rd_stb) begin
            if (reg_sel) rdata = DATA_W'(mask);
            else rdata = sel_svc ? DATA_W'(isr) : DATA_W'(irr);
        end
    end

    // R9: command-port reads follow the readback select.
    assert_readback_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd_stb && !reg_sel && sel_svc) |-> (rdata == DATA_W'(isr)));

    // R1: the interrupt output is low in the first cycle after reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq_out && vec_out == '0));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
// Bench: directed corner cases plus seeded random operations, checked
// against a cycle-level reference model kept in bench variables.
module prio_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, reg_sel = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0, ack_stb = 1'b0;
    logic [7:0] wdata = 8'h00, req = 8'h00;
    logic [7:0] rdata, vec_out;
    logic       irq_out;

    int total = 0;
    int bad = 0;

    // reference model state
    logic [7:0] m_mask = 8'hFF, m_irr = 8'h00, m_isr = 8'h00, m_base = 8'h00;
    logic [7:0] m_prev = 8'h00, m_vec = 8'h00;
    logic       m_aeoi = 1'b0, m_selsvc = 1'b0;
    int         m_st = 0;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .cs(cs), .reg_sel(reg_sel), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata), .req_in(req),
        .irq_out(irq_out), .ack_stb(ack_stb), .vec_out(vec_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int low_idx(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic logic m_irq();
        int p = low_idx(m_irr & ~m_mask);
        int q = low_idx(m_isr);
        return (p < 8) && (p < q);
    endfunction

    function automatic logic [7:0] m_rd(input logic a);
        if (a) return m_mask;
        return m_selsvc ? m_isr : m_irr;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // advance the model by one clock edge using the currently driven inputs
    task automatic model_edge();
        logic [7:0] rise;
        int w;
        rise = req & ~m_prev;
        m_prev = req;
        if (cs && wr_stb && !reg_sel) begin
            if (wdata[4]) begin
                m_mask = 8'h00; m_irr = 8'h00; m_isr = 8'h00; m_selsvc = 1'b0; m_st = 1;
                rise = 8'h00;
            end else if (wdata == 8'h0A) m_selsvc = 1'b0;
            else if (wdata == 8'h0B) m_selsvc = 1'b1;
            else if (wdata[7:3] == 5'b01100) m_isr[wdata[2:0]] = 1'b0;
        end else if (cs && wr_stb && reg_sel) begin
            case (m_st)
                0: m_mask = wdata;
                1: begin m_base = wdata; m_st = 2; end
                2: m_st = 3;
                default: begin m_aeoi = wdata[1]; m_st = 0; end
            endcase
        end
        if (ack_stb) begin
            w = low_idx(m_irr & ~m_mask);
            if (m_irq()) begin
                m_vec = m_base + 8'(w);
                m_irr[w] = 1'b0;
                if (!m_aeoi) m_isr[w] = 1'b1;
            end else m_vec = m_base + 8'd7;
        end
        m_irr = m_irr | rise;
    endtask

    task automatic cycle();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        cs = 0; wr_stb = 0; rd_stb = 0; ack_stb = 0;
        chk("R5 irq_out", irq_out, m_irq());
        chk("R6 vec_out", vec_out, m_vec);
    endtask

    task automatic wr_cmd(input logic [7:0] d);
        cs = 1; wr_stb = 1; reg_sel = 0; wdata = d; cycle();
    endtask

    task automatic wr_dat(input logic [7:0] d);
        cs = 1; wr_stb = 1; reg_sel = 1; wdata = d; cycle();
    endtask

    task automatic do_ack();
        ack_stb = 1; cycle();
    endtask

    task automatic set_req(input logic [7:0] v);
        req = v; cycle();
    endtask

    task automatic rd_chk(input logic a, input string tag);
        cs = 1; rd_stb = 1; reg_sel = a;
        #1;
        chk(tag, rdata, m_rd(a));
        cycle();
    endtask

    task automatic rd_lit(input logic a, input logic [7:0] exp, input string tag);
        cs = 1; rd_stb = 1; reg_sel = a;
        #1;
        chk(tag, rdata, exp);
        cycle();
    endtask

    task automatic setup(input logic [7:0] b, input logic [7:0] ch, input logic [7:0] md);
        wr_cmd(8'h11); wr_dat(b); wr_dat(ch); wr_dat(md);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        chk("R1 irq_out", irq_out, 0);
        chk("R1 vec_out", vec_out, 0);
        rd_lit(1, 8'hFF, "R1 mask");
        rd_lit(0, 8'h00, "R1 request readback");

        // R2: set-up sequence, mask untouched by set-up words
        wr_cmd(8'h11);
        rd_lit(1, 8'h00, "R2 mask cleared");
        wr_dat(8'h20);
        rd_lit(1, 8'h00, "R2 mask held during setup");
        wr_dat(8'h04);
        wr_dat(8'h00);
        // R3: mask load and readback
        wr_dat(8'h3C);
        rd_lit(1, 8'h3C, "R3 mask readback");
        wr_dat(8'h00);

        // R4 / R6: edge capture and acknowledge
        set_req(8'h08);
        chk("R4 irq after edge", irq_out, 1);
        do_ack();
        chk("R6 vector base+3", vec_out, 8'h23);
        rd_lit(0, 8'h00, "R4 held request not re-latched");
        wr_cmd(8'h0B);
        rd_lit(0, 8'h08, "R9 in-service readback");

        // R11: nesting
        set_req(8'h00);
        set_req(8'h08);
        chk("R11 equal level blocked", irq_out, 0);
        set_req(8'h0A);
        chk("R11 higher level passes", irq_out, 1);
        do_ack();
        chk("R11 nested vector", vec_out, 8'h21);
        rd_lit(0, 8'h0A, "R11 two levels in service");

        // R8: specific EOI
        wr_cmd(8'h61);
        rd_lit(0, 8'h08, "R8 only level 1 cleared");
        wr_cmd(8'h63);
        rd_lit(0, 8'h00, "R8 level 3 cleared");
        do_ack();
        chk("R6 pending level 3 served", vec_out, 8'h23);
        wr_cmd(8'h63);
        wr_cmd(8'h0A);
        rd_chk(0, "R9 request readback");

        // R10: spurious acknowledge with input 7 masked
        wr_dat(8'hFF);
        set_req(8'h00);
        set_req(8'h80);
        do_ack();
        chk("R10 spurious vector", vec_out, 8'h27);
        rd_lit(0, 8'h80, "R10 request kept");
        wr_cmd(8'h0B);
        rd_lit(0, 8'h00, "R10 in-service kept");

        // R7: automatic EOI
        setup(8'h40, 8'h02, 8'h02);
        set_req(8'h00);
        set_req(8'h01);
        do_ack();
        chk("R7 auto-eoi vector", vec_out, 8'h40);
        wr_cmd(8'h0B);
        rd_lit(0, 8'h00, "R7 in-service stays empty");

        // random phase against the model
        setup(8'h80, 8'h04, 8'h00);
        for (int n = 0; n < 3000; n++) begin
            int op = $urandom_range(0, 99);
            if (op < 30) set_req(req ^ 8'($urandom));
            else if (op < 40) wr_dat(($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom) & 8'($urandom));
            else if (op < 65) do_ack();
            else if (op < 78) wr_cmd({5'b01100, 3'($urandom)});
            else if (op < 90) rd_chk(1'($urandom), "R9 random readback");
            else if (op < 98) wr_cmd(($urandom_range(0, 1) != 0) ? 8'h0B : 8'h0A);
            else setup(8'($urandom), 8'h04, {6'd0, 1'($urandom), 1'b1});
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule